// File: doc/BRIEF.md
# Token-Counting Pipeline Synchronization Node

This block sits at one node of a statically routed, acyclic processing pipeline. It lies between the node's own processing unit and its two neighbours: the upstream producer and the downstream consumer. The local unit issues one of four synchronization operations at a time on a small issue port. Two operations send a token to a neighbour over a fixed-latency link: a request token goes downstream and an acknowledge token goes upstream. The other two operations wait until a token from a neighbour has arrived, and the block holds the issuing unit with a stall output until one is present.

Tokens that arrive from the neighbours are held in saturating counters. A credit counter limits how many request tokens may be outstanding, so that the producer cannot overrun the consumer's buffer. The depth of all counters is the longest stage distance plus one. The counters can be preloaded, so that a cyclic buffer pattern starts in a defined state. A request sent with no credit left is dropped, and it sets a sticky error flag.

Top module: `tsync_node`

## Requirements
- R1: After reset the request and acknowledge counts are 0 and the credit count is DEPTH (MAX_STAGE_DIST+1, which is 4 by default). After reset op_stall, req_tok_out, ack_tok_out and err_no_credit are all low.
- R2: Operation code 2'b00 (send request) issued with credit above 0 produces a one-cycle pulse on req_tok_out exactly LINK_DLY cycles after the issue cycle (2 by default). It also takes one credit.
- R3: Operation code 2'b10 (send acknowledge) produces a one-cycle pulse on ack_tok_out LINK_DLY cycles after the issue cycle. It needs no credit.
- R4: Operation code 2'b01 (wait request) holds op_stall high while the request count is 0. When the count is above 0 it completes without stalling and consumes one request token.
- R5: Operation code 2'b11 (wait acknowledge) behaves in the same way against the acknowledge count.
- R6: A wait that is stalled in the same cycle that its token arrives stays stalled in that cycle. The stall releases in the next cycle, and completing the wait leaves the count at 0.
- R7: Each pulse on req_tok_in or ack_tok_in adds one to its count. A count never exceeds DEPTH, and tokens that arrive while a count is full are lost.
- R8: Each ack_tok_in pulse also returns one credit. The credit count saturates at DEPTH.
- R9: A send request issued with zero credit emits no token and sets err_no_credit. The flag stays set until reset or a load.
- R10: While load_en is high, the counters take load_credit, load_req and load_ack, each clamped to DEPTH, and err_no_credit clears. Any operation issued in that cycle is not performed, and op_stall is high for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is issued this cycle |
| op_code | input | 2 | 00 send req, 01 wait req, 10 send ack, 11 wait ack |
| op_stall | output | 1 | Issued operation not performed; reissue |
| req_tok_out | output | 1 | Request token pulse to downstream peer |
| ack_tok_out | output | 1 | Acknowledge token pulse to upstream peer |
| req_tok_in | input | 1 | Request token pulse from upstream peer |
| ack_tok_in | input | 1 | Acknowledge token pulse from downstream peer |
| load_en | input | 1 | Preload the counters |
| load_credit | input | CW | Credit preload value |
| load_req | input | CW | Request count preload value |
| load_ack | input | CW | Acknowledge count preload value |
| err_no_credit | output | 1 | Sticky: a send request found no credit |

## Verification
Two functions can fall in the same cycle: a token arriving on a link and a wait consuming a token of the same kind. The bench provokes this by driving req_tok_in high in the very cycle that a wait request is issued against an empty count. It then judges the stall cycle by cycle: high in the first cycle, low in the next one, and high again afterwards because the count is back at 0. The same kind of overlap occurs between a send request and credit exhaustion. The bench checks the token timing with a scoreboard of expected pulse cycles.

// File: rtl/tsync_pkg.sv
package tsync_pkg;

  typedef enum logic [1:0] {
    OP_SEND_REQ = 2'b00,
    OP_WAIT_REQ = 2'b01,
    OP_SEND_ACK = 2'b10,
    OP_WAIT_ACK = 2'b11
  } sync_op_e;

  // Next value of a counter bounded to [0, limit].
  function automatic logic [31:0] sat_step(input logic [31:0] cur, input logic up,
                                           input logic down, input logic [31:0] limit);
    logic [31:0] nxt;
    nxt = cur;
    if (up && !down) nxt = (cur >= limit) ? limit : cur + 32'd1;
    else if (down && !up) nxt = (cur == 32'd0) ? 32'd0 : cur - 32'd1;
    return nxt;
  endfunction

  function automatic logic [31:0] clamp_to(input logic [31:0] val, input logic [31:0] limit);
    return (val > limit) ? limit : val;
  endfunction

endpackage

// File: rtl/tsync_sat_ctr.sv
module tsync_sat_ctr #(
  parameter int DEPTH   = 4,
  parameter int W       = 3,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] cnt,
  output logic         empty
);
  import tsync_pkg::*;

  localparam logic [31:0] LIMIT = 32'(DEPTH);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= W'(RST_VAL);
    else if (load) cnt <= W'(clamp_to(32'(load_val), LIMIT));
    else           cnt <= W'(sat_step(32'(cnt), inc, dec, LIMIT));
  end

  assign empty = (cnt == '0);
endmodule

// File: rtl/tsync_link.sv
module tsync_link #(
  parameter int DLY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tok_in,
  output logic tok_out
);
  generate
    if (DLY <= 1) begin : g_single
      logic stage;
      always_ff @(posedge clk) begin
        if (!rst_n) stage <= 1'b0;
        else        stage <= tok_in;
      end
      assign tok_out = stage;
    end else begin : g_chain
      logic [DLY-1:0] stage;
      always_ff @(posedge clk) begin
        if (!rst_n) stage <= '0;
        else        stage <= {stage[DLY-2:0], tok_in};
      end
      assign tok_out = stage[DLY-1];
    end
  endgenerate
endmodule

// File: rtl/tsync_node.sv
module tsync_node #(
  parameter int MAX_STAGE_DIST = 3,
  parameter int LINK_DLY       = 2,
  localparam int DEPTH         = MAX_STAGE_DIST + 1,
  localparam int CW            = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [1:0]    op_code,
  output logic          op_stall,
  output logic          req_tok_out,
  output logic          ack_tok_out,
  input  logic          req_tok_in,
  input  logic          ack_tok_in,
  input  logic          load_en,
  input  logic [CW-1:0] load_credit,
  input  logic [CW-1:0] load_req,
  input  logic [CW-1:0] load_ack,
  output logic          err_no_credit
);
  import tsync_pkg::*;

  // Named internal events
  logic          op_go;
  logic          is_send_req, is_wait_req, is_send_ack, is_wait_ack;
  logic          req_empty, ack_empty, credit_empty;
  logic          wait_req_done, wait_ack_done;
  logic          wait_blocked;
  logic          req_launch, ack_launch, send_dry;
  logic [CW-1:0] req_cnt, ack_cnt, credit_cnt;

  assign op_go       = op_valid && !load_en;
  assign is_send_req = (sync_op_e'(op_code) == OP_SEND_REQ);
  assign is_wait_req = (sync_op_e'(op_code) == OP_WAIT_REQ);
  assign is_send_ack = (sync_op_e'(op_code) == OP_SEND_ACK);
  assign is_wait_ack = (sync_op_e'(op_code) == OP_WAIT_ACK);

  assign wait_blocked  = (is_wait_req && req_empty) || (is_wait_ack && ack_empty);
  assign wait_req_done = op_go && is_wait_req && !req_empty;
  assign wait_ack_done = op_go && is_wait_ack && !ack_empty;
  assign req_launch    = op_go && is_send_req && !credit_empty;
  assign send_dry      = op_go && is_send_req && credit_empty;
  assign ack_launch    = op_go && is_send_ack;

  assign op_stall = op_valid && (load_en || wait_blocked);

  tsync_sat_ctr #(.DEPTH(DEPTH), .W(CW), .RST_VAL(0)) u_req_ctr (
    .clk(clk), .rst_n(rst_n), .load(load_en), .load_val(load_req),
    .inc(req_tok_in), .dec(wait_req_done), .cnt(req_cnt), .empty(req_empty)
  );

  tsync_sat_ctr #(.DEPTH(DEPTH), .W(CW), .RST_VAL(0)) u_ack_ctr (
    .clk(clk), .rst_n(rst_n), .load(load_en), .load_val(load_ack),
    .inc(ack_tok_in), .dec(wait_ack_done), .cnt(ack_cnt), .empty(ack_empty)
  );

  tsync_sat_ctr #(.DEPTH(DEPTH), .W(CW), .RST_VAL(DEPTH)) u_credit_ctr (
    .clk(clk), .rst_n(rst_n), .load(load_en), .load_val(load_credit),
    .inc(ack_tok_in), .dec(req_launch), .cnt(credit_cnt), .empty(credit_empty)
  );

  tsync_link #(.DLY(LINK_DLY)) u_req_link (
    .clk(clk), .rst_n(rst_n), .tok_in(req_launch), .tok_out(req_tok_out)
  );

  tsync_link #(.DLY(LINK_DLY)) u_ack_link (
    .clk(clk), .rst_n(rst_n), .tok_in(ack_launch), .tok_out(ack_tok_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        err_no_credit <= 1'b0;
    else if (load_en)  err_no_credit <= 1'b0;
    else if (send_dry) err_no_credit <= 1'b1;
  end
endmodule

// File: rtl/tsync_node_chk.sv
module tsync_node_chk #(
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_valid,
  input logic [1:0]    op_code,
  input logic          op_stall,
  input logic          load_en,
  input logic          req_tok_in,
  input logic          err_no_credit,
  input logic [CW-1:0] req_cnt,
  input logic [CW-1:0] credit_cnt
);
  AST_STALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    op_stall |-> (op_valid && (load_en || op_code[0]))); // R4
  AST_REQ_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    req_cnt <= CW'(DEPTH)); // R7
  AST_CREDIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    credit_cnt <= CW'(DEPTH)); // R8
  AST_WAIT_TAKES_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !load_en && op_code == 2'b01 && !op_stall && !req_tok_in)
    |=> req_cnt == $past(req_cnt) - 1'b1); // R4
  AST_SAME_CYCLE_ARRIVAL: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !load_en && op_code == 2'b01 && req_cnt == '0 && req_tok_in)
    |=> req_cnt == CW'(1)); // R6
  AST_DRY_SEND_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !load_en && op_code == 2'b00 && credit_cnt == '0)
    |=> err_no_credit); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_no_credit && !load_en) |=> err_no_credit); // R9
  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> !err_no_credit); // R10
endmodule

bind tsync_node tsync_node_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
  .op_stall(op_stall), .load_en(load_en), .req_tok_in(req_tok_in),
  .err_no_credit(err_no_credit), .req_cnt(req_cnt), .credit_cnt(credit_cnt)
);

// File: tb/tb_tsync_node.sv
module tb_tsync_node;
  localparam int DLY   = 2;
  localparam int DEPTH = 4;
  localparam int CW    = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [1:0] op_code = 2'b00;
  logic op_stall, req_tok_out, ack_tok_out, err_no_credit;
  logic req_tok_in = 1'b0, ack_tok_in = 1'b0, load_en = 1'b0;
  logic [CW-1:0] load_credit = '0, load_req = '0, load_ack = '0;

  int checks = 0, failures = 0, cyc = 0;
  int req_q[$];
  int ack_q[$];
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz
  always @(posedge clk) cyc <= cyc + 1;

  tsync_node #(.MAX_STAGE_DIST(3), .LINK_DLY(DLY)) dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_stall(op_stall), .req_tok_out(req_tok_out), .ack_tok_out(ack_tok_out),
    .req_tok_in(req_tok_in), .ack_tok_in(ack_tok_in), .load_en(load_en),
    .load_credit(load_credit), .load_req(load_req), .load_ack(load_ack),
    .err_no_credit(err_no_credit)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Driver: issue one operation at a falling edge, return at the next falling edge.
  task automatic do_op(input logic [1:0] code, input bit exp_stall, input bit exp_tok,
                       input string tag);
    op_valid = 1'b1;
    op_code  = code;
    #1;
    check(op_stall == exp_stall, tag, op_stall, exp_stall);
    if (exp_tok && code == 2'b00) req_q.push_back(cyc + DLY);
    if (exp_tok && code == 2'b10) ack_q.push_back(cyc + DLY);
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic pulse(input bit r, input bit a, input int n);
    req_tok_in = r;
    ack_tok_in = a;
    repeat (n) @(negedge clk);
    req_tok_in = 1'b0;
    ack_tok_in = 1'b0;
  endtask

  task automatic do_load(input int cr, input int rq, input int ak);
    load_en = 1'b1;
    load_credit = CW'(cr);
    load_req = CW'(rq);
    load_ack = CW'(ak);
    @(negedge clk);
    load_en = 1'b0;
  endtask

  // Monitor: compare token pulses against the scoreboard (R2, R3)
  always @(negedge clk) begin
    if (rst_n) begin
      if (req_tok_out) begin
        if (req_q.size() == 0 || req_q[0] != cyc)
          check(0, "R2 unexpected req token", cyc, (req_q.size() == 0) ? -1 : req_q[0]);
        else begin
          check(1, "R2", 1, 1);
          void'(req_q.pop_front());
        end
      end else if (req_q.size() != 0 && req_q[0] == cyc) begin
        check(0, "R2 missing req token", 0, cyc);
        void'(req_q.pop_front());
      end
      if (ack_tok_out) begin
        if (ack_q.size() == 0 || ack_q[0] != cyc)
          check(0, "R3 unexpected ack token", cyc, (ack_q.size() == 0) ? -1 : ack_q[0]);
        else begin
          check(1, "R3", 1, 1);
          void'(ack_q.pop_front());
        end
      end else if (ack_q.size() != 0 && ack_q[0] == cyc) begin
        check(0, "R3 missing ack token", 0, cyc);
        void'(ack_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      check(0, "watchdog expired", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!op_stall && !req_tok_out && !ack_tok_out && !err_no_credit, "R1 outputs idle",
          {op_stall, req_tok_out, ack_tok_out, err_no_credit}, 0);

    // R4 wait request against empty count, then two tokens
    do_op(2'b01, 1, 0, "R4 empty wait stalls");
    pulse(1, 0, 2);
    do_op(2'b01, 0, 0, "R4 wait 1 completes");
    do_op(2'b01, 0, 0, "R4 wait 2 completes");
    do_op(2'b01, 1, 0, "R4 wait 3 stalls");

    // R6 token arrives in the same cycle as a stalled wait
    op_valid = 1'b1; op_code = 2'b01; req_tok_in = 1'b1;
    #1 check(op_stall == 1, "R6 stall in arrival cycle", op_stall, 1);
    @(negedge clk); req_tok_in = 1'b0;
    #1 check(op_stall == 0, "R6 stall released next cycle", op_stall, 0);
    @(negedge clk);
    #1 check(op_stall == 1, "R6 count back to zero", op_stall, 1);
    op_valid = 1'b0;
    @(negedge clk);

    // R7 saturation: six tokens, only DEPTH kept
    pulse(1, 0, 6);
    for (int i = 0; i < DEPTH; i++) do_op(2'b01, 0, 0, "R7 saturated count drains");
    do_op(2'b01, 1, 0, "R7 tokens beyond DEPTH lost");

    // R5 wait acknowledge
    do_op(2'b11, 1, 0, "R5 empty ack wait stalls");
    pulse(0, 1, 1);
    do_op(2'b11, 0, 0, "R5 ack wait completes");
    do_op(2'b11, 1, 0, "R5 ack count back to zero");

    // R2 / R9 credits: DEPTH sends, then a dry send
    for (int i = 0; i < DEPTH; i++) do_op(2'b00, 0, 1, "R2 send with credit");
    check(!err_no_credit, "R9 no error while credit", err_no_credit, 0);
    do_op(2'b00, 0, 0, "R9 dry send");
    check(err_no_credit, "R9 error set on dry send", err_no_credit, 1);
    repeat (3) @(negedge clk);

    // R8 one credit returned
    pulse(0, 1, 1);
    do_op(2'b00, 0, 1, "R8 returned credit sends");
    check(err_no_credit, "R9 error sticky", err_no_credit, 1);

    // R3 send acknowledge with no credit left
    do_op(2'b10, 0, 1, "R3 send ack needs no credit");
    repeat (3) @(negedge clk);

    // R10 load with a simultaneous operation
    load_en = 1'b1; load_credit = 3'd2; load_req = 3'd7; load_ack = 3'd1;
    op_valid = 1'b1; op_code = 2'b00;
    #1 check(op_stall == 1, "R10 op stalled during load", op_stall, 1);
    @(negedge clk);
    load_en = 1'b0; op_valid = 1'b0;
    check(!err_no_credit, "R10 load clears error", err_no_credit, 1'b0);
    do_op(2'b00, 0, 1, "R10 loaded credit 1");
    do_op(2'b00, 0, 1, "R10 loaded credit 2");
    do_op(2'b00, 0, 0, "R10 loaded credit exhausted");
    check(err_no_credit, "R10 dry after loaded credit", err_no_credit, 1);
    for (int i = 0; i < DEPTH; i++) do_op(2'b01, 0, 0, "R10 loaded req clamped");
    do_op(2'b01, 1, 0, "R10 req clamp limit");
    do_op(2'b11, 0, 0, "R10 loaded ack");
    do_op(2'b11, 1, 0, "R10 loaded ack used");

    // R8 credit saturation
    do_load(0, 0, 0);
    check(!err_no_credit, "R10 reload clears error", err_no_credit, 0);
    pulse(0, 1, 6);
    for (int i = 0; i < DEPTH; i++) do_op(2'b00, 0, 1, "R8 saturated credit sends");
    check(!err_no_credit, "R8 no error within DEPTH", err_no_credit, 0);
    do_op(2'b00, 0, 0, "R8 credit capped at DEPTH");
    check(err_no_credit, "R8 dry beyond DEPTH", err_no_credit, 1);

    repeat (4) @(negedge clk);
    check(req_q.size() == 0, "R2 all req tokens seen", req_q.size(), 0);
    check(ack_q.size() == 0, "R3 all ack tokens seen", ack_q.size(), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule